// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine that places incoming frames into a circular list of two-word descriptors in system memory. Each descriptor's first word carries a buffer pointer, a wrap marker and an ownership flag. Its second word receives the byte count and the first/last-segment markers once the hardware has filled the buffer. Frames arrive as a byte stream with a last-byte marker. The block talks to memory through a single-beat read/write port whose read data returns one cycle after the request.

When a frame starts, the engine reads the current descriptor. If software still holds it, the whole frame is discarded and a one-cycle no-buffer pulse is raised. Otherwise the bytes are packed little-endian into 32-bit words and written to the buffer. If the buffer fills before the frame ends, the descriptor is closed and the frame continues in the next one. Every closed descriptor gets its status word first and then its ownership flag. The ring start address is taken from an input only while reception is switched off.

Top module: `rxring_writer`

## Requirements
- R1: After reset no memory request is issued and `nobuf` is low. While `rx_en` is low, `in_ready` is high.
- R2: Descriptor word 0 holds the buffer address in bits [31:2], the wrap flag in bit 1 and the ownership flag in bit 0. A descriptor is filled only when bit 0 reads 0. Frame byte k of a segment lands at byte address buffer+k, in lane k mod 4 of a 32-bit little-endian word.
- R3: After a descriptor is handed back, the next one is at the ring start if its wrap flag was set, and 8 bytes further on otherwise.
- R4: Status word (descriptor word 1) layout: bits [13:0] hold the segment length, bit 14 is start-of-frame and bit 15 is end-of-frame; all other bits are 0. It is written in the cycle before word 0 is rewritten with bit 0 set and bits [31:1] unchanged.
- R5: A frame whose first descriptor still has bit 0 set is consumed and discarded with no memory write. `nobuf` pulses for one cycle, and the descriptor pointer does not move.
- R6: The ring start is loaded from `ring_base` only while `rx_en` is low and no frame is in progress. Changes made while enabled take effect at the next re-enable.
- R7: Each buffer holds `BUF_BYTES` bytes. A longer frame is chained over consecutive descriptors: start-of-frame is set only in the first, end-of-frame only in the last, and each length is that segment's byte count. A frame that is an exact multiple of `BUF_BYTES` uses no extra descriptor, so no zero-length status is ever written.
- R8: If a chained frame meets a software-owned descriptor, the descriptors already filled stay handed back. The rest of the frame is discarded, `nobuf` pulses, and the next frame starts at that owned descriptor.
- R9: Bytes offered while `rx_en` is low are accepted and discarded, with no memory access and no `nobuf` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Ring start address (8-byte aligned) |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| nobuf | output | 1 | One-cycle pulse: frame lost for lack of a free descriptor |

## Verification
The bench sweeps every frame length from one byte to three full buffers over a three-entry ring. This covers frames that end exactly on a buffer edge, where an off-by-one design would publish an empty trailing descriptor or lose the end-of-frame marker. It fills the ring without releasing descriptors, then checks that a frame arriving at an owned descriptor writes nothing and leaves the pointer in place. It also checks that a chain cut short by an owned descriptor keeps the segment already written. A design that advanced past owned descriptors, or wrote before checking ownership, would corrupt software's data. Finally the ring start is changed both while enabled and while disabled, which separates a design that samples the base continuously from one that latches it.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int AW       = 32;
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int LEN_W    = 14;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;
  localparam logic [AW-1:0] DESC_STEP = 32'd8;
  localparam logic [AW-1:0] STAT_OFS  = 32'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_FILL,
    ST_STAT,
    ST_OWN,
    ST_DROP
  } rxr_state_e;

  // Status word: length, first-segment and last-segment markers.
  function automatic logic [31:0] status_word(input logic [LEN_W-1:0] len,
                                              input logic sof,
                                              input logic eof);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[SOF_BIT]   = sof;
    w[EOF_BIT]   = eof;
    return w;
  endfunction

  // Word 0 as handed back to software: unchanged except the ownership flag.
  function automatic logic [31:0] own_word(input logic [31:0] w0);
    logic [31:0] r;
    r = w0;
    r[OWN_BIT] = 1'b1;
    return r;
  endfunction

  // Buffer start taken from word 0 with the flag bits cleared.
  function automatic logic [AW-1:0] buf_base(input logic [31:0] w0);
    return {w0[31:2], 2'b00};
  endfunction

  // Descriptor that follows the current one.
  function automatic logic [AW-1:0] next_desc(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] base,
                                              input logic wrap);
    return wrap ? base : cur + DESC_STEP;
  endfunction

  // Insert one byte into its lane of a packing word.
  function automatic logic [31:0] lane_merge(input logic [31:0] pack,
                                             input logic [7:0] b,
                                             input logic [1:0] lane);
    logic [31:0] r;
    r = pack;
    r[8*lane +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/rxr_desc_ptr.sv
module rxr_desc_ptr
  import rxr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ptr <= '0;
      base_q  <= '0;
    end else if (load) begin
      cur_ptr <= base_in;
      base_q  <= base_in;
    end else if (advance) begin
      cur_ptr <= next_desc(cur_ptr, base_q, wrap);
    end
  end

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        flush,
  input  logic [7:0]  byte_in,
  input  logic [1:0]  lane,
  output logic [31:0] merged
);

  logic [31:0] pack_q;

  assign merged = lane_merge(pack_q, byte_in, lane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pack_q <= '0;
    end else if (flush) begin
      pack_q <= '0;
    end else if (take) begin
      pack_q <= merged;
    end
  end

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  input  logic [AW-1:0] cur_ptr,
  input  logic [31:0]   merged,
  input  logic [31:0]   mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          take,
  output logic          flush,
  output logic [1:0]    lane,
  output logic          idle,
  output logic          advance,
  output logic          desc_wrap,
  output logic [AW-1:0] buf_addr,
  output logic          ev_data,
  output logic          ev_status,
  output logic          ev_publish,
  output logic          ev_drop,
  output logic          drop_active
);

  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam logic [CNT_W:0] BUF_LIM = (CNT_W+1)'(BUF_BYTES);

  rxr_state_e       state_q, state_d;
  logic [CNT_W-1:0] bcnt_q;
  logic             first_q;
  logic             last_q;
  logic [31:0]      word0_q;
  logic             full_after;
  logic             close_seg;
  logic             owned;
  logic [AW-1:0]    data_addr;

  assign lane       = bcnt_q[1:0];
  assign take       = (state_q == ST_FILL) && in_valid;
  assign full_after = (({1'b0, bcnt_q} + 1'b1) == BUF_LIM);
  assign close_seg  = take && (in_last || full_after);
  assign flush      = take && ((lane == 2'd3) || in_last || full_after);
  assign owned      = mem_rdata[OWN_BIT];
  assign buf_addr   = buf_base(word0_q);
  assign desc_wrap  = word0_q[WRAP_BIT];
  assign data_addr  = buf_addr + {{(AW-CNT_W){1'b0}}, bcnt_q[CNT_W-1:2], 2'b00};
  assign idle       = (state_q == ST_IDLE);

  assign ev_data     = flush;
  assign ev_status   = (state_q == ST_STAT);
  assign ev_publish  = (state_q == ST_OWN);
  assign drop_active = (state_q == ST_DROP);

  always_comb begin
    state_d   = state_q;
    in_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    advance   = 1'b0;
    ev_drop   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!rx_en) begin
          in_ready = 1'b1;
        end else if (in_valid) begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (owned) begin
          ev_drop = 1'b1;
          state_d = ST_DROP;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        in_ready = 1'b1;
        if (flush) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = data_addr;
          mem_wdata = merged;
        end
        if (close_seg) state_d = ST_STAT;
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + STAT_OFS;
        mem_wdata = status_word(LEN_W'(bcnt_q), first_q, last_q);
        state_d   = ST_OWN;
      end
      ST_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr;
        mem_wdata = own_word(word0_q);
        advance   = 1'b1;
        state_d   = last_q ? ST_IDLE : ST_FETCH;
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      word0_q <= '0;
    end else begin
      state_q <= state_d;
      if (idle && rx_en && in_valid) begin
        first_q <= 1'b1;
        last_q  <= 1'b0;
      end
      if (state_q == ST_WAIT) begin
        bcnt_q <= '0;
        if (!owned) word0_q <= mem_rdata;
      end
      if (take) begin
        bcnt_q <= bcnt_q + 1'b1;
        last_q <= in_last;
      end
      if (state_q == ST_OWN) first_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        nobuf
);

  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] base_q;
  logic [AW-1:0] buf_addr;
  logic [31:0]   merged;
  logic          take;
  logic          flush;
  logic [1:0]    lane;
  logic          idle;
  logic          advance;
  logic          desc_wrap;
  logic          ptr_load;
  logic          ev_data;
  logic          ev_status;
  logic          ev_publish;
  logic          ev_drop;
  logic          drop_active;

  assign ptr_load = idle && !rx_en;
  assign nobuf    = ev_drop;

  rxr_desc_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .base_in (ring_base),
    .advance (advance),
    .wrap    (desc_wrap),
    .cur_ptr (cur_ptr),
    .base_q  (base_q)
  );

  rxr_packer u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .flush   (flush),
    .byte_in (in_data),
    .lane    (lane),
    .merged  (merged)
  );

  rxr_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .cur_ptr     (cur_ptr),
    .merged      (merged),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .take        (take),
    .flush       (flush),
    .lane        (lane),
    .idle        (idle),
    .advance     (advance),
    .desc_wrap   (desc_wrap),
    .buf_addr    (buf_addr),
    .ev_data     (ev_data),
    .ev_status   (ev_status),
    .ev_publish  (ev_publish),
    .ev_drop     (ev_drop),
    .drop_active (drop_active)
  );

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int BUF_BYTES = 1536
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] cur_ptr,
  input logic [31:0] base_q,
  input logic [31:0] buf_addr,
  input logic        advance,
  input logic        desc_wrap,
  input logic        ev_data,
  input logic        ev_status,
  input logic        ev_publish,
  input logic        ev_drop,
  input logic        drop_active
);

  AST_STATUS_BEFORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_publish |-> $past(ev_status)); // R4

  AST_PUBLISH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_publish |-> (mem_req && mem_we && mem_wdata[0] && mem_addr == cur_ptr)); // R4

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && desc_wrap) |=> (cur_ptr == base_q)); // R3

  AST_STEP_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !desc_wrap) |=> (cur_ptr == $past(cur_ptr) + 32'd8)); // R3

  AST_NONZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status |-> (mem_wdata[13:0] != 14'd0 && 32'(mem_wdata[13:0]) <= BUF_BYTES)); // R7

  AST_DATA_INSIDE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |-> ((mem_addr - buf_addr) < 32'(BUF_BYTES))); // R2

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_active || ev_drop) |-> !(mem_req && mem_we)); // R5

  AST_NOBUF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !ev_drop); // R5

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en)) |-> $stable(base_q)); // R6

endmodule

bind rxring_writer rxr_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .cur_ptr     (cur_ptr),
  .base_q      (base_q),
  .buf_addr    (buf_addr),
  .advance     (advance),
  .desc_wrap   (desc_wrap),
  .ev_data     (ev_data),
  .ev_status   (ev_status),
  .ev_publish  (ev_publish),
  .ev_drop     (ev_drop),
  .drop_active (drop_active)
);

// File: tb/sim_rxring_writer.sv
module sim_rxring_writer;

  localparam int BUF = 8;
  localparam logic [31:0] RA = 32'h100, BA = 32'h400, SA = 32'h100;
  localparam logic [31:0] RB = 32'h180, BB = 32'h700, SB = 32'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [31:0] ring_base = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready, mem_req, mem_we, nobuf;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];
  int wcount = 0;
  int nbcount = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rxring_writer #(.BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .nobuf(nobuf)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (mem_req) mem_rdata <= mem[mem_addr[11:2]];
    if (nobuf) nbcount <= nbcount + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int seed, input int i);
    return 8'((seed + i * 3) & 255);
  endfunction

  task automatic setup_desc(input logic [31:0] rb, input int idx, input logic [31:0] b, input bit w);
    mem[(rb + 32'(8 * idx)) >> 2]     = b | {30'd0, w, 1'b0};
    mem[(rb + 32'(8 * idx) + 4) >> 2] = '0;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      bit acc;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = fb(seed, i);
        in_last  = (i == len - 1);
        acc      = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic verify_desc(input logic [31:0] dp, input logic [31:0] b, input bit w, input int len,
                             input bit sof, input bit eof, input int seed, input int off, input string req);
    logic [31:0] w0, st, ew0, est;
    bit ok;
    logic [7:0] got;
    w0  = mem[dp >> 2];
    st  = mem[(dp + 4) >> 2];
    ew0 = b | {30'd0, w, 1'b1};
    est = {16'd0, eof, sof, 14'(len)};
    chk(w0 == ew0, {req, " R4 word0"}, w0, ew0);
    chk(st == est, {req, " R4 status"}, st, est);
    ok = 1'b1;
    for (int j = 0; j < len; j++) begin
      got = 8'(mem[(b + 32'(j)) >> 2] >> (8 * (j % 4)));
      if (got != fb(seed, off + j)) ok = 1'b0;
    end
    chk(ok, {req, " R2 data"}, b, 32'(len));
  endtask

  task automatic check_frame(input logic [31:0] rb, input logic [31:0] bb, input logic [31:0] stride,
                             input int nd, inout int idx, input int len, input int seed,
                             input string req, input bit rel);
    int rem, off, c;
    bit w;
    rem = len;
    off = 0;
    while (rem > 0) begin
      c = (rem > BUF) ? BUF : rem;
      w = (idx == nd - 1);
      verify_desc(rb + 32'(8 * idx), bb + stride * 32'(idx), w, c, off == 0, rem <= BUF, seed, off, req);
      if (rel) setup_desc(rb, idx, bb + stride * 32'(idx), w);
      off += c;
      rem -= c;
      idx = (idx + 1) % nd;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ia, ib, nb0, w0;
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    for (int k = 0; k < 3; k++) setup_desc(RA, k, BA + SA * 32'(k), k == 2);
    setup_desc(RB, 0, BB, 1'b0);
    setup_desc(RB, 1, BB + SB, 1'b1);
    ring_base = RA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
    chk(nobuf == 1'b0, "R1 nobuf", 32'(nobuf), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    rx_en = 1'b1;

    // R2 R3 R7: length sweep over three full buffers
    ia = 0;
    for (int len = 1; len <= 3 * BUF; len++) begin
      send_frame(len, len * 11);
      check_frame(RA, BA, SA, 3, ia, len, len * 11, (len <= BUF) ? "R2" : "R7", 1'b1);
    end

    // R5: ring full of software-owned descriptors
    for (int f = 0; f < 3; f++) begin
      send_frame(5, 20 + f);
      check_frame(RA, BA, SA, 3, ia, 5, 20 + f, "R5", 1'b0);
    end
    nb0 = nbcount;
    w0  = wcount;
    send_frame(6, 40);
    chk(nbcount == nb0 + 1, "R5 nobuf pulse", 32'(nbcount - nb0), 32'd1);
    chk(wcount == w0, "R5 no write", 32'(wcount - w0), 32'd0);
    chk(mem[RA >> 2] == (BA | 32'd1), "R5 word0 kept", mem[RA >> 2], BA | 32'd1);
    chk(mem[(RA + 4) >> 2] == 32'h0000C005, "R5 status kept", mem[(RA + 4) >> 2], 32'h0000C005);

    // R8: chain cut short by an owned descriptor
    setup_desc(RA, 0, BA, 1'b0);
    nb0 = nbcount;
    send_frame(20, 50);
    verify_desc(RA, BA, 1'b0, BUF, 1'b1, 1'b0, 50, 0, "R8");
    chk(nbcount == nb0 + 1, "R8 nobuf pulse", 32'(nbcount - nb0), 32'd1);
    for (int k = 0; k < 3; k++) setup_desc(RA, k, BA + SA * 32'(k), k == 2);
    ia = 1;
    send_frame(3, 60);
    check_frame(RA, BA, SA, 3, ia, 3, 60, "R8", 1'b1);

    // R6: base change while enabled is held back
    ring_base = RB;
    send_frame(4, 70);
    check_frame(RA, BA, SA, 3, ia, 4, 70, "R6", 1'b1);
    chk(ia == 0, "R3 wrap index", 32'(ia), 32'd0);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    ib = 0;
    send_frame(10, 80);
    check_frame(RB, BB, SB, 2, ib, 10, 80, "R6", 1'b1);
    send_frame(2, 90);
    check_frame(RB, BB, SB, 2, ib, 2, 90, "R3", 1'b1);

    // R9: bytes while disabled are discarded
    rx_en = 1'b0;
    @(negedge clk);
    nb0 = nbcount;
    w0  = wcount;
    send_frame(6, 99);
    chk(wcount == w0, "R9 no write", 32'(wcount - w0), 32'd0);
    chk(nbcount == nb0, "R9 no nobuf", 32'(nbcount - nb0), 32'd0);
    chk(mem[RB >> 2] == BB, "R9 ring untouched", mem[RB >> 2], BB);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule